// File: doc/BRIEF.md
# Word Shifter with Overflow Flag

This unit is the shift stage of a CPU datapath. It takes a 16-bit word and moves it left or right by a variable number of positions. Four shift kinds are supported: logical and arithmetic, each in either direction. The number of positions comes from a small immediate field in the instruction or from the contents of a data register. Alongside the shifted word, the unit produces five condition flags: carry, extend, negative, zero and overflow.

The arithmetic kinds report overflow when the sign bit takes a different value at any of the single-bit steps that make up the whole shift. A comparison of only the first and last sign bit would miss some of these cases. The logical kinds never report overflow.

A request is accepted on any cycle where `in_valid` is high. The word and flags are registered and appear on the next cycle, with `out_valid` marking that cycle. The outputs hold their values until the next request arrives.

Top module: `word_shifter`

## Requirements
- R1: A request with `in_valid` high yields `out_valid` high on the following cycle, with the result and flags for that request. With `in_valid` low, `out_valid` is low on the next cycle and the result and all flags keep their values.
- R2: The count source is selected by `cnt_from_reg`. When it is 0, the count is `imm_count`, and an `imm_count` of 0 means a count of 8. When it is 1, the count is `reg_count` modulo 64 (its low 6 bits), and all higher bits are ignored.
- R3: `shift_kind` 2'b00 is a logical right shift. A 0 enters bit 15 at every step, so a count of 16 or more gives 0.
- R4: `shift_kind` 2'b10 is an arithmetic right shift. Bit 15 keeps its value at every step, so a count of 16 or more fills the word with the original bit 15. Its overflow flag is 0.
- R5: `shift_kind` 2'b01 (logical left) and 2'b11 (arithmetic left) both insert 0 into bit 0 at every step, so a count of 16 or more gives 0.
- R6: Both logical kinds (2'b00 and 2'b01) always clear the overflow flag.
- R7: The arithmetic left kind sets the overflow flag when bit 15 changes value during at least one step. For a count n from 1 to 15, this means the top n+1 bits of the operand are not all equal. For n of 16 or more, it means the operand is nonzero.
- R8: The carry flag is the last bit shifted out. When the count exceeds 16, this is 0 for the logical right and both left kinds, and the original bit 15 for the arithmetic right kind.
- R9: When the count is nonzero, the extend flag takes the new carry value. When the count is 0, the result equals the operand, carry and overflow are 0, and extend keeps its previous value.
- R10: The negative flag equals result bit 15. The zero flag is 1 exactly when the 16-bit result is 0.
- R11: Synchronous active-high reset clears `out_valid`, the result and all five flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| shift_kind | input | 2 | {arithmetic, left} shift kind |
| cnt_from_reg | input | 1 | 1: count from register value, 0: from immediate |
| imm_count | input | 3 | Immediate count, 0 means 8 |
| reg_count | input | 32 | Register value used as count (modulo 64) |
| operand | input | 16 | Word to shift |
| out_valid | output | 1 | Result valid strobe |
| result | output | 16 | Shifted word |
| flag_c | output | 1 | Carry: last bit shifted out |
| flag_x | output | 1 | Extend: copy of carry for nonzero counts |
| flag_n | output | 1 | Negative: result bit 15 |
| flag_z | output | 1 | Zero: result is zero |
| flag_v | output | 1 | Overflow |

## Verification
Every operation completes in a single registered stage, so most faults show at the ports on the cycle right after the request. A wrong count decode or wrong fill bit shows as a wrong result word. A wrong sign-change test shows as a wrong overflow flag. The extend flag is the only state carried from one request to the next. A fault there, for example an update on a zero count, surfaces only on a later request, so the vectors follow a zero-count request with checks that the earlier extend value is still present.

// File: rtl/word_shifter_pkg.sv
package word_shifter_pkg;
  // Bit 1 selects arithmetic, bit 0 selects left.
  typedef enum logic [1:0] {
    SK_LSR = 2'b00,
    SK_LSL = 2'b01,
    SK_ASR = 2'b10,
    SK_ASL = 2'b11
  } shift_kind_e;
endpackage

// File: rtl/shf_count_sel.sv
module shf_count_sel #(
  parameter int IMM_W = 3,
  parameter int REG_W = 32,
  parameter int CNT_W = 6
) (
  input  logic             from_reg,
  input  logic [IMM_W-1:0] imm,
  input  logic [REG_W-1:0] regv,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] IMM_ZERO_CNT = CNT_W'(1 << IMM_W);

  logic unused_reg_hi;
  assign unused_reg_hi = ^regv[REG_W-1:CNT_W];

  always_comb begin
    if (from_reg)       cnt = regv[CNT_W-1:0];
    else if (imm == '0) cnt = IMM_ZERO_CNT;
    else                cnt = CNT_W'(imm);
  end
endmodule

// File: rtl/shf_barrel.sv
module shf_barrel #(
  parameter int W     = 16,
  parameter int CNT_W = 6
) (
  input  logic [W-1:0]     op,
  input  logic [CNT_W-1:0] cnt,
  input  logic             left,
  input  logic             arith,
  output logic [W-1:0]     res,
  output logic             carry
);
  logic fill;
  int   n;

  always_comb begin
    n    = int'(cnt);
    fill = arith & ~left & op[W-1];
    for (int i = 0; i < W; i++) begin
      if (left) begin
        if (i >= n) res[i] = op[i-n];
        else        res[i] = 1'b0;
      end else begin
        if (i + n < W) res[i] = op[i+n];
        else           res[i] = fill;
      end
    end
    if (n == 0)      carry = 1'b0;
    else if (n <= W) carry = left ? op[W-n] : op[n-1];
    else             carry = left ? 1'b0 : fill;
  end
endmodule

// File: rtl/shf_ovf_detect.sv
module shf_ovf_detect #(
  parameter int W     = 16,
  parameter int CNT_W = 6
) (
  input  logic [W-1:0]     op,
  input  logic [CNT_W-1:0] cnt,
  output logic             sign_changed
);
  int n;

  always_comb begin
    n = int'(cnt);
    sign_changed = 1'b0;
    if (n >= W) begin
      // Every bit reaches the sign position, then zeros follow.
      sign_changed = |op;
    end else if (n > 0) begin
      for (int i = 0; i < W - 1; i++) begin
        if (i >= W - 1 - n && op[i] != op[W-1]) sign_changed = 1'b1;
      end
    end
  end
endmodule

// File: rtl/word_shifter.sv
module word_shifter
  import word_shifter_pkg::*;
#(
  parameter int W     = 16,
  parameter int IMM_W = 3,
  parameter int REG_W = 32,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [1:0]       shift_kind,
  input  logic             cnt_from_reg,
  input  logic [IMM_W-1:0] imm_count,
  input  logic [REG_W-1:0] reg_count,
  input  logic [W-1:0]     operand,
  output logic             out_valid,
  output logic [W-1:0]     result,
  output logic             flag_c,
  output logic             flag_x,
  output logic             flag_n,
  output logic             flag_z,
  output logic             flag_v
);
  shift_kind_e      kind;
  logic [CNT_W-1:0] cnt;
  logic [W-1:0]     sh_res;
  logic             sh_carry;
  logic             sign_chg;
  logic             cnt_nz;

  assign kind   = shift_kind_e'(shift_kind);
  assign cnt_nz = (cnt != '0);

  shf_count_sel #(.IMM_W(IMM_W), .REG_W(REG_W), .CNT_W(CNT_W)) u_cnt (
    .from_reg (cnt_from_reg),
    .imm      (imm_count),
    .regv     (reg_count),
    .cnt      (cnt)
  );

  shf_barrel #(.W(W), .CNT_W(CNT_W)) u_barrel (
    .op    (operand),
    .cnt   (cnt),
    .left  (shift_kind[0]),
    .arith (shift_kind[1]),
    .res   (sh_res),
    .carry (sh_carry)
  );

  shf_ovf_detect #(.W(W), .CNT_W(CNT_W)) u_ovf (
    .op           (operand),
    .cnt          (cnt),
    .sign_changed (sign_chg)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      flag_c    <= 1'b0;
      flag_x    <= 1'b0;
      flag_n    <= 1'b0;
      flag_z    <= 1'b0;
      flag_v    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= sh_res;
        flag_c <= sh_carry;
        flag_n <= sh_res[W-1];
        flag_z <= (sh_res == '0);
        flag_v <= (kind == SK_ASL) & sign_chg;
        if (cnt_nz) flag_x <= sh_carry;
      end
    end
  end

  // R1: strobe follows the request by one cycle
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R1: idle cycles leave the result alone
  a_r1_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(result) && $stable(flag_x)));
  // R3: logical right with a nonzero count clears the top bit
  a_r3_lsr_zero_fill: assert property (@(posedge clk) disable iff (rst)
    (in_valid && kind == SK_LSR && cnt_nz) |=> !result[W-1]);
  // R4: arithmetic right keeps the sign bit
  a_r4_asr_sign_keep: assert property (@(posedge clk) disable iff (rst)
    (in_valid && kind == SK_ASR) |=> (result[W-1] == $past(operand[W-1]) && !flag_v));
  // R5: left shifts with a nonzero count clear bit 0
  a_r5_left_zero_in: assert property (@(posedge clk) disable iff (rst)
    (in_valid && shift_kind[0] && cnt_nz) |=> !result[0]);
  // R6: logical kinds never flag overflow
  a_r6_logical_v_clear: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !shift_kind[1]) |=> !flag_v);
  // R9: zero count keeps extend and passes the operand through
  a_r9_x_hold: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !cnt_nz) |=> ($stable(flag_x) && !flag_c && result == $past(operand)));
  // R9: nonzero count copies carry into extend
  a_r9_x_tracks_c: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cnt_nz) |=> (flag_x == flag_c));
endmodule

// File: tb/word_shifter_bench.sv
module word_shifter_bench;
  typedef struct packed {
    logic [1:0]  kind;
    logic        src;
    logic [2:0]  imm;
    logic [31:0] regv;
    logic [15:0] op;
    logic [15:0] res;
    logic        c;
    logic        v;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{2'b00, 1'b0, 3'd1, 32'd0,          16'h8001, 16'h4000, 1'b1, 1'b0}, // R3 R8
    '{2'b00, 1'b0, 3'd0, 32'd0,          16'hABCD, 16'h00AB, 1'b1, 1'b0}, // R2 imm 0 -> 8
    '{2'b10, 1'b0, 3'd4, 32'd0,          16'h8070, 16'hF807, 1'b0, 1'b0}, // R4
    '{2'b10, 1'b1, 3'd0, 32'd20,         16'h8000, 16'hFFFF, 1'b1, 1'b0}, // R4 R8 beyond width
    '{2'b01, 1'b0, 3'd3, 32'd0,          16'h1234, 16'h91A0, 1'b0, 1'b0}, // R5 R6
    '{2'b11, 1'b0, 3'd3, 32'd0,          16'h1234, 16'h91A0, 1'b0, 1'b1}, // R7
    '{2'b11, 1'b0, 3'd2, 32'd0,          16'hE000, 16'h8000, 1'b1, 1'b0}, // R7 no change
    '{2'b11, 1'b1, 3'd0, 32'd1,          16'h4000, 16'h8000, 1'b0, 1'b1}, // R7
    '{2'b11, 1'b1, 3'd0, 32'd16,         16'hFFFF, 16'h0000, 1'b1, 1'b1}, // R7 R8 R10
    '{2'b11, 1'b1, 3'd0, 32'd17,         16'h0000, 16'h0000, 1'b0, 1'b0}, // R7 saturated
    '{2'b00, 1'b1, 3'd0, 32'd64,         16'h8421, 16'h8421, 1'b0, 1'b0}, // R2 R9 zero count
    '{2'b01, 1'b1, 3'd0, 32'd16,         16'h0001, 16'h0000, 1'b1, 1'b0}, // R5 R8
    '{2'b00, 1'b1, 3'd0, 32'h0000_0045,  16'h0100, 16'h0008, 1'b0, 1'b0}, // R2 modulo
    '{2'b10, 1'b0, 3'd0, 32'd0,          16'h7F80, 16'h007F, 1'b1, 1'b0}, // R4 R8
    '{2'b01, 1'b1, 3'd0, 32'hFFFF_0002,  16'hC003, 16'h000C, 1'b1, 1'b0}  // R2 high bits ignored
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [1:0]  shift_kind = '0;
  logic        cnt_from_reg = 1'b0;
  logic [2:0]  imm_count = '0;
  logic [31:0] reg_count = '0;
  logic [15:0] operand = '0;
  logic        out_valid;
  logic [15:0] result;
  logic        flag_c, flag_x, flag_n, flag_z, flag_v;

  int checks = 0;
  int fails  = 0;
  logic exp_x = 1'b0;

  always #10 clk = ~clk;

  word_shifter u_word_shifter (
    .clk(clk), .rst(rst), .in_valid(in_valid), .shift_kind(shift_kind),
    .cnt_from_reg(cnt_from_reg), .imm_count(imm_count), .reg_count(reg_count),
    .operand(operand), .out_valid(out_valid), .result(result),
    .flag_c(flag_c), .flag_x(flag_x), .flag_n(flag_n), .flag_z(flag_z),
    .flag_v(flag_v)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input vec_t t);
    @(negedge clk);
    in_valid = 1'b1; shift_kind = t.kind; cnt_from_reg = t.src;
    imm_count = t.imm; reg_count = t.regv; operand = t.op;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R11 reset state", {25'd0, out_valid, flag_c, flag_x, flag_n, flag_z, flag_v},
          32'd0);
    check("R11 reset result", {16'd0, result}, 32'd0);

    for (int k = 0; k < NV; k++) begin
      vec_t t;
      int   cnt;
      t = VECS[k];
      cnt = t.src ? int'(t.regv[5:0]) : ((t.imm == 3'd0) ? 8 : int'(t.imm));
      if (cnt != 0) exp_x = t.c;
      issue(t);
      check("R1 out_valid", {31'd0, out_valid}, 32'd1);
      check("R3 R4 R5 result", {16'd0, result}, {16'd0, t.res});
      check("R8 carry", {31'd0, flag_c}, {31'd0, t.c});
      check("R6 R7 overflow", {31'd0, flag_v}, {31'd0, t.v});
      check("R9 extend", {31'd0, flag_x}, {31'd0, exp_x});
      check("R10 negative", {31'd0, flag_n}, {31'd0, t.res[15]});
      check("R10 zero", {31'd0, flag_z}, {31'd0, (t.res == 16'd0)});
    end

    // R1: an idle cycle with changed inputs leaves outputs alone
    operand = 16'h5555; shift_kind = 2'b11; imm_count = 3'd1; cnt_from_reg = 1'b0;
    @(negedge clk);
    check("R1 idle out_valid", {31'd0, out_valid}, 32'd0);
    check("R1 idle result held", {16'd0, result}, 32'h000C);
    check("R1 idle carry held", {31'd0, flag_c}, 32'd1);

    // R9: set extend to 1, then a zero count must keep it and clear carry
    issue('{2'b01, 1'b0, 3'd1, 32'd0, 16'h8000, 16'h0000, 1'b1, 1'b0});
    check("R9 extend set", {31'd0, flag_x}, 32'd1);
    issue('{2'b10, 1'b1, 3'd0, 32'd128, 16'h8001, 16'h8001, 1'b0, 1'b0});
    check("R9 zero count extend kept", {31'd0, flag_x}, 32'd1);
    check("R9 zero count carry", {31'd0, flag_c}, 32'd0);
    check("R9 zero count result", {16'd0, result}, 32'h8001);
    check("R4 R9 zero count overflow", {31'd0, flag_v}, 32'd0);

    // R11: reset clears the extend flag again
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R11 reset clears extend", {31'd0, flag_x}, 32'd0);
    check("R11 reset clears result", {16'd0, result}, 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule